// File: doc/BRIEF.md
# Serial Register Access Port

This block lets a microcontroller read and write one byte-wide internal register at a time over a synchronous serial link. Every transfer is framed by an active-low chip select. The first eight serial clocks carry a command byte, made of a read/write flag and a register address. The next eight carry the data byte. On a write, the block raises a single-cycle write strobe on a parallel register interface once the last data bit has arrived. On a read, it fetches the addressed byte from that interface and shifts it out.

A static mode input sets the pin usage. In shared mode, one bidirectional data pin carries both directions and bits travel LSB first. In split mode, one pin only transmits, a second pin only receives, and bits travel MSB first. The bidirectional pin is represented by separate input, output and output-enable ports. All pins are sampled by the block's own clock through a synchronizer, so the serial clock must be much slower than that clock.

Top module: `serial_reg_port`

## Requirements
- R1: While chip select (`cs_ni`) is high, `data1_oe_o` is 0 and no transfer is in progress. A transfer begins only when chip select goes low.
- R2: Serial bits are sampled on rising edges of `sclk_i`. The high and low phases of `sclk_i` must each last at least 4 cycles of `clk_i`. The assembled command byte holds the read flag in bit 7 (1 = read, 0 = write) and the register address in bits 6:0. These bit positions hold in both modes.
- R3: In shared mode (`mode_i` = 0), received bits come from `data1_i` with each byte LSB first, and `data2_i` is ignored.
- R4: In split mode (`mode_i` = 1), received bits come from `data2_i` with each byte MSB first.
- R5: A write transfer with 16 rising edges produces exactly one single-cycle `reg_we_o` pulse, carrying the command address and the data byte. The pulse comes within 6 clock cycles after the 16th edge and is issued even if chip select rises 2 cycles after that edge.
- R6: If chip select rises before the 16th rising edge, no write pulse is issued and register contents stay unchanged.
- R7: Rising edges after the 16th are ignored until chip select goes high: they cause no second write and do not corrupt the transfer.
- R8: On a read transfer, the byte returned on `reg_rdata_i` for the command address is sent on `data1_o`. Bit order follows the mode (LSB first in shared mode, MSB first in split mode). Data bit k is valid when `sclk_i` rises for the (9+k)-th time.
- R9: In shared mode, `data1_oe_o` is 1 only during the data phase of a read. In split mode it is 1 whenever chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, oversamples the serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 0 shared single-pin LSB-first, 1 split-pin MSB-first |
| cs_ni | input | 1 | Active-low chip select framing a transfer |
| sclk_i | input | 1 | Serial clock from the microcontroller |
| data1_i | input | 1 | Input side of the first data pin |
| data2_i | input | 1 | Second data pin, receive in split mode |
| data1_o | output | 1 | Output side of the first data pin |
| data1_oe_o | output | 1 | Drive enable for the first data pin |
| reg_addr_o | output | 7 | Register address from the command byte |
| reg_wdata_o | output | 8 | Write data byte |
| reg_we_o | output | 1 | Single-cycle write strobe |
| reg_rdata_i | input | 8 | Read data for `reg_addr_o` |

## Verification
Two events can land in the same clock cycle: the write strobe that follows the 16th serial edge, and the counter clear caused by chip select rising. The bench provokes this by raising chip select only two clock cycles after the final rising edge, so the synchronized release arrives while the strobe is out. A pass requires exactly one write with the right address and data, confirmed by reading the register back. The opposite case, a release after the 15th edge, must leave the earlier contents readable and produce no strobe.

// File: rtl/mport_pkg.sv
package mport_pkg;
  parameter int unsigned ADDR_W_DEF = 7;
  parameter int unsigned DATA_W_DEF = 8;
  parameter int unsigned SYNC_STAGES_DEF = 2;

  typedef enum logic {
    MODE_SHARED = 1'b0,
    MODE_SPLIT  = 1'b1
  } port_mode_e;
endpackage

// File: rtl/mport_sync.sv
module mport_sync #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
    end else begin
      chain[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/mport_frame.sv
module mport_frame
  import mport_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  port_mode_e        mode_i,
  input  logic              cs_s_i,
  input  logic              sclk_s_i,
  input  logic              din_s_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              we_o,
  output logic              is_read_o,
  output logic              data_phase_o,
  output logic              dout_o
);
  localparam int unsigned CMD_W = ADDR_W + 1;
  localparam int unsigned TOT   = CMD_W + DATA_W;
  localparam int unsigned CNT_W = $clog2(TOT + 1);
  localparam int unsigned IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [CNT_W-1:0]  cnt;
  logic [CMD_W-1:0]  cmd_sr, cmd_nxt;
  logic [DATA_W-1:0] dat_sr, dat_nxt, rd_byte;
  logic              sclk_q, ld_q, wr_q, rise;
  logic [CNT_W-1:0]  off;
  logic [IDX_W-1:0]  sel;

  assign rise = sclk_s_i & ~sclk_q;

  // bit order per mode: split shifts toward MSB, shared toward LSB
  always_comb begin
    if (mode_i == MODE_SPLIT) begin
      cmd_nxt = {cmd_sr[CMD_W-2:0], din_s_i};
      dat_nxt = {dat_sr[DATA_W-2:0], din_s_i};
    end else begin
      cmd_nxt = {din_s_i, cmd_sr[CMD_W-1:1]};
      dat_nxt = {din_s_i, dat_sr[DATA_W-1:1]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt     <= '0;
      cmd_sr  <= '0;
      dat_sr  <= '0;
      rd_byte <= '0;
      sclk_q  <= 1'b0;
      ld_q    <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      sclk_q <= sclk_s_i;
      ld_q   <= 1'b0;
      wr_q   <= 1'b0;
      if (cs_s_i) begin
        cnt <= '0;
      end else if (rise && cnt < CNT_W'(TOT)) begin
        cnt <= cnt + CNT_W'(1);
        if (cnt < CNT_W'(CMD_W)) cmd_sr <= cmd_nxt;
        else                     dat_sr <= dat_nxt;
        ld_q <= (cnt == CNT_W'(CMD_W - 1));
        wr_q <= (cnt == CNT_W'(TOT - 1)) && !cmd_sr[CMD_W-1];
      end
      if (ld_q && cmd_sr[CMD_W-1]) rd_byte <= rdata_i;
    end
  end

  assign addr_o       = cmd_sr[ADDR_W-1:0];
  assign wdata_o      = dat_sr;
  assign we_o         = wr_q;
  assign is_read_o    = cmd_sr[CMD_W-1];
  assign data_phase_o = (cnt >= CNT_W'(CMD_W)) && (cnt < CNT_W'(TOT));

  always_comb begin
    off = cnt - CNT_W'(CMD_W);
    sel = (mode_i == MODE_SPLIT) ? IDX_W'(DATA_W - 1) - off[IDX_W-1:0] : off[IDX_W-1:0];
  end

  assign dout_o = data_phase_o & is_read_o & rd_byte[sel];

  assert_we_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_q |=> !wr_q);
  assert_we_at_end_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_q |-> cnt == CNT_W'(TOT));
  assert_cnt_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CNT_W'(TOT));
  assert_cs_clears_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s_i |=> cnt == '0);
  assert_cnt_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt != $past(cnt)) |-> (cnt == '0 || cnt == $past(cnt) + CNT_W'(1)));
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
  import mport_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              data1_i,
  input  logic              data2_i,
  output logic              data1_o,
  output logic              data1_oe_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  port_mode_e mode;
  logic [3:0] pins_s;
  logic       cs_s, sclk_s, d1_s, d2_s, din_s;
  logic       is_read, data_phase;

  assign mode = port_mode_e'(mode_i);

  mport_sync #(
    .WIDTH  (4),
    .STAGES (SYNC_STAGES),
    .RST_VAL(4'b1000)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i, data1_i, data2_i}),
    .q_o   (pins_s)
  );

  assign {cs_s, sclk_s, d1_s, d2_s} = pins_s;
  assign din_s = (mode == MODE_SPLIT) ? d2_s : d1_s;

  mport_frame #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode),
    .cs_s_i      (cs_s),
    .sclk_s_i    (sclk_s),
    .din_s_i     (din_s),
    .rdata_i     (reg_rdata_i),
    .addr_o      (reg_addr_o),
    .wdata_o     (reg_wdata_o),
    .we_o        (reg_we_o),
    .is_read_o   (is_read),
    .data_phase_o(data_phase),
    .dout_o      (data1_o)
  );

  // raw chip select gates the driver so release is immediate
  assign data1_oe_o = ~cs_ni & ((mode == MODE_SPLIT) | (data_phase & is_read));
endmodule

// File: tb/serial_reg_port_bench.sv
`timescale 1ns/1ps
module serial_reg_port_bench;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0, cs_n = 1'b1, sclk = 1'b0, d1 = 1'b0, d2 = 1'b0;
  logic data1_o, data1_oe, we;
  logic [6:0] addr;
  logic [7:0] wdata;
  logic [7:0] rf [128];
  logic [7:0] exp_mem [128];
  logic [14:0] wq [$];
  wire  pin = data1_oe ? data1_o : d1;
  wire  [7:0] rdata = rf[addr];
  int n_run = 0, n_fail = 0;
  bit done = 0;
  bit prev_we = 0;

  always #5 clk = ~clk;

  serial_reg_port u_serial_reg_port (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .cs_ni(cs_n), .sclk_i(sclk),
    .data1_i(pin), .data2_i(d2), .data1_o(data1_o), .data1_oe_o(data1_oe),
    .reg_addr_o(addr), .reg_wdata_o(wdata), .reg_we_o(we), .reg_rdata_i(rdata)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // per-clock reference comparison: writes against the expected queue, idle driver
  always @(negedge clk) begin
    if (rst_n) begin
      if (cs_n) check(!data1_oe, "R1 driver idle", data1_oe, 0);
      if (we) begin
        check(!prev_we, "R5 single-cycle strobe", prev_we, 0);
        if (wq.size() == 0) check(0, "R6 unexpected write", {addr, wdata}, 0);
        else begin
          logic [14:0] e;
          e = wq.pop_front();
          check({addr, wdata} == e, "R5 write addr/data", {addr, wdata}, e);
        end
        rf[addr] = wdata;
      end
      prev_we = we;
    end
  end

  task automatic xfer(input bit split, input bit rd, input logic [6:0] a, input logic [7:0] d,
                      input int nedges, input int gap, input string tag);
    logic [7:0] cmd, got, by;
    logic b;
    cmd = {rd, a};
    got = '0;
    if (!rd && nedges >= 16) begin
      wq.push_back({a, d});
      exp_mem[a] = d;
    end
    mode = split;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nedges; i++) begin
      by = (i < 8) ? cmd : (i < 16) ? d : 8'h5A;
      b = split ? by[7 - (i % 8)] : by[i % 8];
      if (split) begin d2 = b; d1 = ~b; end
      else begin d1 = b; d2 = ~b; end
      repeat (HALF) @(negedge clk);
      check(data1_oe == (split || (rd && i >= 8 && i < 16)), "R9 drive enable", data1_oe, i);
      if (rd && i >= 8 && i < 16) begin
        if (split) got[15 - i] = pin;
        else       got[i - 8]  = pin;
      end
      sclk = 1'b1;
      if (i == nedges - 1) break;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (gap) @(negedge clk);
    cs_n = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
    repeat (HALF) @(negedge clk);
    check(!data1_oe, "R1 released", data1_oe, 0);
    if (rd) check(got == exp_mem[a], tag, got, exp_mem[a]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    report();
  end

  initial begin
    for (int k = 0; k < 128; k++) begin
      rf[k] = 8'(k * 3 + 1);
      exp_mem[k] = 8'(k * 3 + 1);
    end
    repeat (3) @(negedge clk);
    check(!we && !data1_oe, "R1 reset state", {we, data1_oe}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R3: shared write, garbage on data2
    xfer(0, 0, 7'h05, 8'hA5, 16, HALF, "R3 write");
    // R4: split write
    xfer(1, 0, 7'h33, 8'h3C, 16, HALF, "R4 write");
    // R8: reads in both orders
    xfer(0, 1, 7'h33, 8'h00, 16, HALF, "R8 shared read");
    xfer(1, 1, 7'h05, 8'h00, 16, HALF, "R8 split read");
    xfer(1, 1, 7'h40, 8'h00, 16, HALF, "R8 split read default");
    // R2/R3/R4 order: asymmetric byte written one way, read the other
    xfer(0, 0, 7'h01, 8'h01, 16, HALF, "R3 order write");
    xfer(1, 1, 7'h01, 8'h00, 16, HALF, "R4 order read");
    xfer(1, 0, 7'h7E, 8'h80, 16, HALF, "R4 order write");
    xfer(0, 1, 7'h7E, 8'h00, 16, HALF, "R3 order read");
    // R6: aborted writes
    xfer(0, 0, 7'h05, 8'h11, 15, HALF, "R6 abort 15");
    xfer(1, 0, 7'h05, 8'h22, 8, HALF, "R6 abort 8");
    xfer(0, 1, 7'h05, 8'h00, 16, HALF, "R6 contents kept");
    // R7: extra edges
    xfer(1, 0, 7'h10, 8'h77, 20, HALF, "R7 write");
    xfer(0, 1, 7'h10, 8'h00, 16, HALF, "R7 readback");
    xfer(0, 1, 7'h33, 8'h00, 19, HALF, "R7 long read");
    // R5: release right behind the last edge
    xfer(0, 0, 7'h22, 8'hC3, 16, 2, "R5 late write");
    xfer(1, 1, 7'h22, 8'h00, 16, HALF, "R5 coincident readback");
    repeat (20) @(negedge clk);
    check(wq.size() == 0, "R5 all writes seen", wq.size(), 0);
    report();
  end
endmodule